// File: doc/BRIEF.md
# Power-Down Entry and Wakeup Controller

This controller puts a processor core into a low-power state and brings it back. Software requests sleep by issuing an I/O write to a reserved address pattern. The controller then waits until the bus grant lets that access happen on the bus. Only then does it withdraw the core pipeline clock enable and block instruction issue. Until the access is performed, the core keeps running. Timer, interrupt, refresh and I/O control logic stay on an always-on enable that is never withdrawn.

While asleep, a refresh request or a bus request opens a short window. During the window the limited bus/refresh clock enable is raised and instruction issue stays blocked. The window closes when both requests drop. Any interrupt request ends the low-power state, and so does reset. An interrupt that arrives while the controller is still waiting for the grant cancels the entry. Clock gating cells are represented only by their enable signals.

Top module: `pwrdn_ctrl`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the controller returns to the running state: `core_clk_en`=1, `bus_clk_en`=1, `aon_clk_en`=1, `issue_block`=0. This holds from any state, including sleep.
- R2: A sleep request is recognised only from an `io_wr` pulse whose `io_addr` has bits 27, 25, 24 and 23 at 1 and bit 22 at 0; all other address bits are ignored. A write with any other value in those five bits leaves `core_clk_en` at 1 even after `bus_grant` is given.
- R3: After a matching write, while `bus_grant` stays low, `core_clk_en` stays 1 and `issue_block` stays 0.
- R4: In the cycle after `bus_grant` is seen high while a matching request is pending (and no `irq`), `core_clk_en`=0, `bus_clk_en`=0 and `issue_block`=1.
- R5: `aon_clk_en` is 1 in every state.
- R6: While asleep, a cycle with `refresh_req` or `bus_req` high and `irq` low gives, in the next cycle, `bus_clk_en`=1, `core_clk_en`=0 and `issue_block`=1.
- R7: During such a window, the first cycle with both `refresh_req` and `bus_req` low (and `irq` low) returns the controller to sleep, so that `bus_clk_en`=0 in the following cycle.
- R8: An `irq` seen while asleep or in a window gives `core_clk_en`=1, `bus_clk_en`=1 and `issue_block`=0 in the next cycle.
- R9: An `irq` seen while a request waits for the grant cancels the request. A later `bus_grant` then does not put the core to sleep.
- R10: If `irq` and `bus_grant` are both high while a request is pending, the interrupt wins and the core never sleeps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr | input | 1 | I/O write strobe from the core |
| io_addr | input | ADDR_W | I/O write address |
| bus_grant | input | 1 | Bus granted; the pending access is performed |
| irq | input | 1 | Any interrupt request |
| refresh_req | input | 1 | Memory refresh cycle request |
| bus_req | input | 1 | External bus arbitration request |
| core_clk_en | output | 1 | Enable for the core pipeline clock |
| bus_clk_en | output | 1 | Enable for the bus/refresh clock |
| aon_clk_en | output | 1 | Enable for the timer, interrupt and I/O control domain |
| issue_block | output | 1 | Blocks instruction issue |

## Verification
The bench builds the block with its default 32-bit address and the default match pattern. Only five address bits are decoded, so the bench sweeps all 32 combinations of those bits. The undecoded bits are filled with varying values on each write. Every matching case then runs through entry, refresh and arbitration windows and interrupt wakeup. The cancel, interrupt-versus-grant and reset-while-asleep orderings are driven separately.

// File: rtl/pwrdn_pkg.sv
// Shared types for the power-down controller.
// Assumes: nothing beyond the standard language.
package pwrdn_pkg;
    typedef enum logic [1:0] {
        PD_RUN     = 2'd0,
        PD_PENDING = 2'd1,
        PD_SLEEP   = 2'd2,
        PD_WINDOW  = 2'd3
    } pd_state_e;
endpackage

// File: rtl/pwrdn_addr_match.sv
// Decodes the reserved I/O write address that requests sleep.
// Assumes: MATCH_MASK marks the decoded bits, MATCH_VALUE their required value.
module pwrdn_addr_match #(
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] MATCH_MASK  = 32'h0BC0_0000,
    parameter logic [ADDR_W-1:0] MATCH_VALUE = 32'h0B80_0000
) (
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              sleep_hit
);
    logic [ADDR_W-1:0] bit_ok;

    // Per-bit compare; a bit outside the mask always agrees.
    genvar gi;
    generate
        for (gi = 0; gi < ADDR_W; gi++) begin : g_bit
            assign bit_ok[gi] = !MATCH_MASK[gi] || (io_addr[gi] == MATCH_VALUE[gi]);
        end
    endgenerate

    // A hit needs a write strobe and every decoded bit in agreement.
    assign sleep_hit = io_wr && (&bit_ok);
endmodule

// File: rtl/pwrdn_fsm.sv
// Sequencer for power-down entry, temporary wake windows and wakeup.
// Assumes: bus_grant high while pending means the sleep access is performed.
module pwrdn_fsm
    import pwrdn_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sleep_hit,
    input  logic      bus_grant,
    input  logic      irq,
    input  logic      refresh_req,
    input  logic      bus_req,
    output pd_state_e state
);
    pd_state_e state_nx;
    logic      wake_need;

    assign wake_need = refresh_req || bus_req;

    // Next-state selection; the interrupt has priority in every low-power state.
    always_comb begin
        state_nx = state;
        unique case (state)
            PD_RUN:     if (sleep_hit) state_nx = PD_PENDING;
            PD_PENDING: if (irq) state_nx = PD_RUN;
                        else if (bus_grant) state_nx = PD_SLEEP;
            PD_SLEEP:   if (irq) state_nx = PD_RUN;
                        else if (wake_need) state_nx = PD_WINDOW;
            PD_WINDOW:  if (irq) state_nx = PD_RUN;
                        else if (!wake_need) state_nx = PD_SLEEP;
            default:    state_nx = PD_RUN;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PD_RUN;
        else        state <= state_nx;
    end

    // R9
    // pend_cancel_chk
    pend_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PD_PENDING && irq) |=> (state == PD_RUN));

    // R3
    // run_no_direct_sleep_chk
    run_no_direct_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PD_RUN) |=> (state != PD_SLEEP && state != PD_WINDOW));
endmodule

// File: rtl/pwrdn_enables.sv
// Turns the controller state into clock enables and the issue block flag.
// Assumes: the enables drive external clock gating cells.
module pwrdn_enables
    import pwrdn_pkg::*;
(
    input  pd_state_e state,
    output logic      core_clk_en,
    output logic      bus_clk_en,
    output logic      aon_clk_en,
    output logic      issue_block
);
    // Core runs until the sleep access is performed.
    always_comb core_clk_en = (state == PD_RUN) || (state == PD_PENDING);

    // The limited clock runs whenever the core does, and inside wake windows.
    always_comb bus_clk_en = core_clk_en || (state == PD_WINDOW);

    // No instruction issues while sleeping or inside a window.
    always_comb issue_block = (state == PD_SLEEP) || (state == PD_WINDOW);

    // The always-on domain keeps its clock in every state.
    assign aon_clk_en = 1'b1;
endmodule

// File: rtl/pwrdn_ctrl.sv
// Top of the power-down controller: decode, sequencer, enable outputs.
// Assumes: synchronous active-low reset; inputs are synchronous to clk.
module pwrdn_ctrl
    import pwrdn_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] MATCH_MASK  = 32'h0BC0_0000,
    parameter logic [ADDR_W-1:0] MATCH_VALUE = 32'h0B80_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              bus_grant,
    input  logic              irq,
    input  logic              refresh_req,
    input  logic              bus_req,
    output logic              core_clk_en,
    output logic              bus_clk_en,
    output logic              aon_clk_en,
    output logic              issue_block
);
    logic      sleep_hit;
    pd_state_e state;

    pwrdn_addr_match #(
        .ADDR_W      (ADDR_W),
        .MATCH_MASK  (MATCH_MASK),
        .MATCH_VALUE (MATCH_VALUE)
    ) u_match (
        .io_wr     (io_wr),
        .io_addr   (io_addr),
        .sleep_hit (sleep_hit)
    );

    pwrdn_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_hit   (sleep_hit),
        .bus_grant   (bus_grant),
        .irq         (irq),
        .refresh_req (refresh_req),
        .bus_req     (bus_req),
        .state       (state)
    );

    pwrdn_enables u_en (
        .state       (state),
        .core_clk_en (core_clk_en),
        .bus_clk_en  (bus_clk_en),
        .aon_clk_en  (aon_clk_en),
        .issue_block (issue_block)
    );

    // R4
    // sleep_entry_chk
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_clk_en && !issue_block && state == PD_PENDING && bus_grant && !irq)
        |=> (!core_clk_en && !bus_clk_en && issue_block));

    // R8
    // irq_wake_chk
    irq_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_block && irq) |=> (core_clk_en && bus_clk_en && !issue_block));

    // R6
    // window_open_chk
    window_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_block && !bus_clk_en && !irq && (refresh_req || bus_req))
        |=> (bus_clk_en && !core_clk_en && issue_block));

    // R7
    // window_close_chk
    window_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_block && bus_clk_en && !irq && !refresh_req && !bus_req)
        |=> (!bus_clk_en && issue_block));

    // R5
    // aon_on_chk
    aon_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aon_clk_en && $stable(aon_clk_en));
endmodule

// File: tb/pwrdn_ctrl_tb.sv
module pwrdn_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic [31:0] io_addr = '0;
    logic        bus_grant = 1'b0;
    logic        irq = 1'b0;
    logic        refresh_req = 1'b0;
    logic        bus_req = 1'b0;
    logic        core_clk_en, bus_clk_en, aon_clk_en, issue_block;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    pwrdn_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .bus_grant(bus_grant), .irq(irq), .refresh_req(refresh_req),
        .bus_req(bus_req), .core_clk_en(core_clk_en), .bus_clk_en(bus_clk_en),
        .aon_clk_en(aon_clk_en), .issue_block(issue_block)
    );

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s core/bus/aon/blk actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [3:0] outs();
        return {core_clk_en, bus_clk_en, aon_clk_en, issue_block};
    endfunction

    localparam logic [3:0] O_RUN   = 4'b1110;
    localparam logic [3:0] O_SLEEP = 4'b0011;
    localparam logic [3:0] O_WIN   = 4'b0111;

    task automatic matching_write();
        io_addr = $urandom();
        io_addr[27] = 1'b1; io_addr[25] = 1'b1; io_addr[24] = 1'b1;
        io_addr[23] = 1'b1; io_addr[22] = 1'b0;
        io_wr = 1'b1; step(); io_wr = 1'b0;
    endtask

    initial begin
        #1;
        step(); step();
        chk("R1 reset", outs(), O_RUN);
        rst_n = 1'b1;
        step();
        chk("R1 after reset", outs(), O_RUN);

        // R2 sweep of all decoded-bit combinations
        for (int k = 0; k < 32; k++) begin
            bit hit;
            hit = (k == 5'b11110);
            io_addr = $urandom();
            io_addr[22] = k[0]; io_addr[23] = k[1]; io_addr[24] = k[2];
            io_addr[25] = k[3]; io_addr[27] = k[4];
            io_wr = 1'b1; step(); io_wr = 1'b0;
            chk("R3 waiting grant", outs(), O_RUN);
            step();
            chk("R3 still waiting", outs(), O_RUN);
            bus_grant = 1'b1; step(); bus_grant = 1'b0;
            chk(hit ? "R4 entry" : "R2 no match", outs(), hit ? O_SLEEP : O_RUN);
            if (hit) begin
                chk("R5 aon in sleep", {3'b000, aon_clk_en}, 4'b0001);
                refresh_req = 1'b1; step();
                chk("R6 refresh window", outs(), O_WIN);
                step();
                chk("R6 window held", outs(), O_WIN);
                refresh_req = 1'b0; step();
                chk("R7 back to sleep", outs(), O_SLEEP);
                bus_req = 1'b1; step();
                chk("R6 arbitration window", outs(), O_WIN);
                irq = 1'b1; step(); irq = 1'b0; bus_req = 1'b0;
                chk("R8 wake from window", outs(), O_RUN);
            end
        end

        // R8 wake directly from sleep
        matching_write();
        bus_grant = 1'b1; step(); bus_grant = 1'b0;
        chk("R4 entry again", outs(), O_SLEEP);
        step();
        chk("R4 sleep holds", outs(), O_SLEEP);
        irq = 1'b1; step(); irq = 1'b0;
        chk("R8 wake from sleep", outs(), O_RUN);

        // R9 cancel while pending
        matching_write();
        irq = 1'b1; step(); irq = 1'b0;
        chk("R9 cancelled", outs(), O_RUN);
        bus_grant = 1'b1; step(); bus_grant = 1'b0;
        chk("R9 grant after cancel", outs(), O_RUN);

        // R10 interrupt and grant together
        matching_write();
        irq = 1'b1; bus_grant = 1'b1; step(); irq = 1'b0; bus_grant = 1'b0;
        chk("R10 irq beats grant", outs(), O_RUN);
        step();
        chk("R10 stays running", outs(), O_RUN);

        // R1 reset while asleep
        matching_write();
        bus_grant = 1'b1; step(); bus_grant = 1'b0;
        chk("R4 entry before reset", outs(), O_SLEEP);
        rst_n = 1'b0; step();
        chk("R1 reset from sleep", outs(), O_RUN);
        rst_n = 1'b1; step();
        chk("R1 running after reset", outs(), O_RUN);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule